// File: doc/BRIEF.md
# SDRAM Command-Bus Protocol Monitor

This block is a passive observer placed beside an SDRAM controller. Once per clock it samples the command bus (chip select, row strobe, column strobe, write enable, bank address, the auto-precharge address bit and clock enable). From these it keeps its own model of which of the four banks holds an open row. It also counts the clocks between related commands. Any command that breaks a state precondition or comes too early after an earlier command produces a one-cycle error pulse and a 4-bit code that names the broken rule.

All spacings are parameters in clock cycles. The defaults assume a 10 ns memory clock: 20 ns becomes 2 clocks, 50 ns becomes 5, 70 ns becomes 7 and 100 us becomes 10000. A refresh watchdog arms once the system reports that initialization is finished. It then flags any stretch of 1562 clocks that passes without an auto refresh. A sticky flag collects every error until software clears it. The block only observes: it never drives the bus, and it does not look at data or analogue timing.

Top module: `sdram_cmd_monitor`

## Requirements
- R12: A command is decoded only when cs_n_i is low. {ras_n_i,cas_n_i,we_n_i} = 011 is activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 110 burst stop and 111 no-op. A command seen at clock edge N sets err_pulse_o for the single cycle after edge N. err_code_o then holds that code until the next error or a clear. When several rules break at once, the lowest code wins.
- R1: A read or write to a bank whose row is idle gives code 1.
- R2: A mode set or refresh while any bank is open gives code 2.
- R3: A read or write fewer than T_RCD (2) clocks after the activate of the same bank gives code 3.
- R4: An activate fewer than T_RP (2) clocks after the same bank closed gives code 4. An activate fewer than T_RC (7) clocks after the previous activate of the same bank gives code 7.
- R5: Precharging a bank fewer than T_RAS_MIN (5) clocks after its activate gives code 5. A bank still open T_RAS_MAX (10000) clocks after its activate, with no precharge in that cycle, gives code 6 once.
- R6: An activate fewer than T_RRD (2) clocks after any activate gives code 8. An activate to an already open bank gives code 13 and leaves that bank's timing unchanged.
- R7: Any command fewer than T_MRD (2) clocks after a mode set gives code 9.
- R8: Bit n of bank_open_o shows bank n. Activate opens the bank chosen by ba_i. Precharge with a10_i low closes only that bank. Precharge with a10_i high closes all banks whatever ba_i holds. Precharge of an idle bank has no effect.
- R9: A read or write with a10_i high to an open bank starts an auto-precharge burst of BURST_LEN (4) cycles. Any read or write during those cycles gives code 10. After the burst the bank closes, and that closure starts its T_RP interval.
- R10: Any command issued when cke_i was low in the previous cycle gives code 11.
- R11: While init_done_i is high, T_REFI (1562) clocks without a refresh give code 12 in the 1562nd clock, and the window then starts again.
- R13: After reset all outputs are zero. err_sticky_o is set by every error and cleared by clr_i. An error in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Clears the sticky flag and the held code |
| init_done_i | input | 1 | Arms the refresh watchdog |
| cke_i | input | 1 | Observed clock enable |
| cs_n_i | input | 1 | Observed chip select, active low |
| ras_n_i | input | 1 | Observed row strobe, active low |
| cas_n_i | input | 1 | Observed column strobe, active low |
| we_n_i | input | 1 | Observed write enable, active low |
| ba_i | input | 2 | Observed bank address |
| a10_i | input | 1 | Observed auto-precharge / all-bank address bit |
| err_pulse_o | output | 1 | One-cycle error indication |
| err_sticky_o | output | 1 | Accumulated error flag |
| err_code_o | output | 4 | Code of the most recent error |
| bank_open_o | output | 4 | Per-bank open-row state |

## Verification
On every cycle the assertions check the following: reads and writes to idle banks, and refresh or mode set with open banks, are flagged; activate opens its bank; an all-bank precharge leaves every bank closed; a command after a low clock enable is flagged; every pulse carries a non-zero code and the sticky flag; and a clear drops the flag unless an error arrives with it. The exact spacing limits, the choice of code when several rules break together, the auto-precharge window and the cycle in which the long-open-row and refresh watchdogs fire can only be shown by the bench's scripted command sequences.

// File: rtl/sdram_mon_pkg.sv
// Shared types for the SDRAM command monitor: decoded commands and error codes.
package sdram_mon_pkg;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
    } cmd_e;

    // Lower value = higher priority when several rules break together.
    typedef enum logic [3:0] {
        ERR_NONE      = 4'd0,
        ERR_RW_IDLE   = 4'd1,
        ERR_BUSY_ALL  = 4'd2,
        ERR_RCD       = 4'd3,
        ERR_RP        = 4'd4,
        ERR_RAS_MIN   = 4'd5,
        ERR_RAS_MAX   = 4'd6,
        ERR_RC        = 4'd7,
        ERR_RRD       = 4'd8,
        ERR_MRD       = 4'd9,
        ERR_AP_BURST  = 4'd10,
        ERR_CKE       = 4'd11,
        ERR_REFI      = 4'd12,
        ERR_ACT_OPEN  = 4'd13
    } err_e;

    localparam int NUM_CODES = 16;

endpackage

// File: rtl/sdram_cmd_decode.sv
// Command decoder: turns the strobes into one command value.
// Assumes: chip select high or the all-high strobe pattern means no command.
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cs_n_i,
    input  logic ras_n_i,
    input  logic cas_n_i,
    input  logic we_n_i,
    output cmd_e cmd_o
);
    // Map the strobe triple to a command when the device is selected.
    always_comb begin
        cmd_o = CMD_NONE;
        if (!cs_n_i) begin
            unique case ({ras_n_i, cas_n_i, we_n_i})
                3'b011:  cmd_o = CMD_ACT;
                3'b101:  cmd_o = CMD_RD;
                3'b100:  cmd_o = CMD_WR;
                3'b010:  cmd_o = CMD_PRE;
                3'b001:  cmd_o = CMD_REF;
                3'b000:  cmd_o = CMD_MRS;
                3'b110:  cmd_o = CMD_BST;
                default: cmd_o = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sdram_bank_track.sv
// One bank's row state and its two distance counters.
// Counters load 1 on their event and count up, saturating at SAT, so the
// value seen in a cycle is the clock distance to the event.
// Assumes: act_i is only raised for an idle bank; close_i wins over act_i.
module sdram_bank_track #(
    parameter int               CNT_W = 14,
    parameter logic [CNT_W-1:0] SAT   = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             close_i,
    output logic             open_o,
    output logic [CNT_W-1:0] since_act_o,
    output logic [CNT_W-1:0] since_pre_o
);
    // Open/closed state of the row.
    always_ff @(posedge clk) begin
        if (!rst_n)       open_o <= 1'b0;
        else if (close_i) open_o <= 1'b0;
        else if (act_i)   open_o <= 1'b1;
    end

    // Distance since this bank's last activate.
    always_ff @(posedge clk) begin
        if (!rst_n)                  since_act_o <= SAT;
        else if (act_i && !close_i)  since_act_o <= CNT_W'(1);
        else if (since_act_o != SAT) since_act_o <= since_act_o + 1'b1;
    end

    // Distance since this bank last closed.
    always_ff @(posedge clk) begin
        if (!rst_n)                  since_pre_o <= SAT;
        else if (close_i)            since_pre_o <= CNT_W'(1);
        else if (since_pre_o != SAT) since_pre_o <= since_pre_o + 1'b1;
    end
endmodule

// File: rtl/sdram_refresh_watch.sv
// Refresh watchdog: flags when T_REFI clocks pass with no refresh while armed.
// The window restarts after a flag. Assumes: enable_i is stable once set.
module sdram_refresh_watch #(
    parameter int T_REFI = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic ref_i,
    output logic late_o
);
    localparam int          RW    = $clog2(T_REFI + 1);
    localparam logic [RW-1:0] LIMIT = RW'(T_REFI);

    logic [RW-1:0] dist_q;

    assign late_o = enable_i && !ref_i && (dist_q == LIMIT);

    // Clock distance to the last refresh, held at 1 while disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n)                        dist_q <= RW'(1);
        else if (!enable_i || ref_i || late_o) dist_q <= RW'(1);
        else                               dist_q <= dist_q + 1'b1;
    end
endmodule

// File: rtl/sdram_cmd_monitor.sv
// SDRAM command-bus protocol monitor (top).
// Tracks per-bank rows, checks state preconditions and clock spacings,
// and reports the lowest-numbered broken rule as a one-cycle pulse with a
// held code and a sticky flag. Assumes: all spacings given in clocks.
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RAS_MIN = 5,
    parameter int T_RAS_MAX = 10000,
    parameter int T_RC      = 7,
    parameter int T_RRD     = 2,
    parameter int T_MRD     = 2,
    parameter int T_REFI    = 1562,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 init_done_i,
    input  logic                 cke_i,
    input  logic                 cs_n_i,
    input  logic                 ras_n_i,
    input  logic                 cas_n_i,
    input  logic                 we_n_i,
    input  logic [BA_W-1:0]      ba_i,
    input  logic                 a10_i,
    output logic                 err_pulse_o,
    output logic                 err_sticky_o,
    output logic [3:0]           err_code_o,
    output logic [NUM_BANKS-1:0] bank_open_o
);
    localparam int                 SAT_I  = T_RAS_MAX + 1;
    localparam int                 CNT_W  = $clog2(SAT_I + 1);
    localparam logic [CNT_W-1:0]   SAT    = CNT_W'(SAT_I);
    localparam logic [CNT_W-1:0]   RCD_C  = CNT_W'(T_RCD);
    localparam logic [CNT_W-1:0]   RP_C   = CNT_W'(T_RP);
    localparam logic [CNT_W-1:0]   RMIN_C = CNT_W'(T_RAS_MIN);
    localparam logic [CNT_W-1:0]   RMAX_C = CNT_W'(T_RAS_MAX);
    localparam logic [CNT_W-1:0]   RC_C   = CNT_W'(T_RC);
    localparam logic [CNT_W-1:0]   RRD_C  = CNT_W'(T_RRD);
    localparam logic [CNT_W-1:0]   MRD_C  = CNT_W'(T_MRD);
    localparam int                 AP_W   = $clog2(BURST_LEN + 1);

    cmd_e                 cmd;
    logic [NUM_BANKS-1:0] act_hit, pre_hit, close_hit, ap_close;
    logic [CNT_W-1:0]     since_act [NUM_BANKS];
    logic [CNT_W-1:0]     since_pre [NUM_BANKS];
    logic [CNT_W-1:0]     since_any_act, since_mrs;
    logic [AP_W-1:0]      ap_cnt;
    logic [BA_W-1:0]      ap_bank;
    logic                 ap_busy, ap_start, is_rw, sel_open, cke_q, ref_late;
    logic [NUM_CODES-1:0] viol;
    err_e                 code_c, code_q;

    sdram_cmd_decode u_dec (
        .cs_n_i(cs_n_i), .ras_n_i(ras_n_i), .cas_n_i(cas_n_i),
        .we_n_i(we_n_i), .cmd_o(cmd)
    );

    // One tracker per bank, with its activate/close strobes.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign pre_hit[b]   = (cmd == CMD_PRE) && (a10_i || ba_i == BA_W'(b));
        assign ap_close[b]  = (ap_cnt == AP_W'(1)) && (ap_bank == BA_W'(b));
        assign close_hit[b] = (pre_hit[b] && bank_open_o[b]) || ap_close[b];
        assign act_hit[b]   = (cmd == CMD_ACT) && (ba_i == BA_W'(b)) && !bank_open_o[b];

        sdram_bank_track #(.CNT_W(CNT_W), .SAT(SAT)) u_bank (
            .clk(clk), .rst_n(rst_n), .act_i(act_hit[b]), .close_i(close_hit[b]),
            .open_o(bank_open_o[b]), .since_act_o(since_act[b]),
            .since_pre_o(since_pre[b])
        );
    end

    sdram_refresh_watch #(.T_REFI(T_REFI)) u_refw (
        .clk(clk), .rst_n(rst_n), .enable_i(init_done_i),
        .ref_i(cmd == CMD_REF), .late_o(ref_late)
    );

    assign is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign sel_open = bank_open_o[ba_i];
    assign ap_busy  = (ap_cnt != '0);
    assign ap_start = is_rw && a10_i && sel_open && !ap_busy;

    // Distances to the last activate on any bank and to the last mode set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_any_act <= SAT;
            since_mrs     <= SAT;
        end else begin
            if (cmd == CMD_ACT)            since_any_act <= CNT_W'(1);
            else if (since_any_act != SAT) since_any_act <= since_any_act + 1'b1;
            if (cmd == CMD_MRS)            since_mrs <= CNT_W'(1);
            else if (since_mrs != SAT)     since_mrs <= since_mrs + 1'b1;
        end
    end

    // Auto-precharge burst window and the clock enable of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ap_cnt  <= '0;
            ap_bank <= '0;
            cke_q   <= 1'b1;
        end else begin
            cke_q <= cke_i;
            if (ap_start) begin
                ap_cnt  <= AP_W'(BURST_LEN);
                ap_bank <= ba_i;
            end else if (ap_busy) begin
                ap_cnt <= ap_cnt - 1'b1;
            end
        end
    end

    // Rule evaluation for the command in this cycle.
    always_comb begin
        viol = '0;
        unique case (cmd)
            CMD_ACT: begin
                viol[ERR_RP]       = since_pre[ba_i] < RP_C;
                viol[ERR_RC]       = since_act[ba_i] < RC_C;
                viol[ERR_RRD]      = since_any_act < RRD_C;
                viol[ERR_ACT_OPEN] = sel_open;
            end
            CMD_RD, CMD_WR: begin
                viol[ERR_RW_IDLE]  = !sel_open;
                viol[ERR_AP_BURST] = ap_busy;
                viol[ERR_RCD]      = sel_open && (since_act[ba_i] < RCD_C);
            end
            CMD_PRE: begin
                for (int b = 0; b < NUM_BANKS; b++)
                    if (pre_hit[b] && bank_open_o[b] && since_act[b] < RMIN_C)
                        viol[ERR_RAS_MIN] = 1'b1;
            end
            CMD_REF, CMD_MRS: viol[ERR_BUSY_ALL] = |bank_open_o;
            default: ;
        endcase
        if (cmd != CMD_NONE) begin
            viol[ERR_MRD] = since_mrs < MRD_C;
            viol[ERR_CKE] = !cke_q;
        end
        for (int b = 0; b < NUM_BANKS; b++)
            if (bank_open_o[b] && since_act[b] == RMAX_C && !pre_hit[b])
                viol[ERR_RAS_MAX] = 1'b1;
        viol[ERR_REFI] = ref_late;
    end

    // Priority pick: the lowest violated code.
    always_comb begin
        code_c = ERR_NONE;
        for (int i = NUM_CODES - 1; i >= 1; i--)
            if (viol[i]) code_c = err_e'(i);
    end

    // Registered reporting: pulse, held code and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse_o  <= 1'b0;
            err_sticky_o <= 1'b0;
            code_q       <= ERR_NONE;
        end else begin
            err_pulse_o  <= |viol;
            err_sticky_o <= (clr_i ? 1'b0 : err_sticky_o) | (|viol);
            if (|viol)      code_q <= code_c;
            else if (clr_i) code_q <= ERR_NONE;
        end
    end

    assign err_code_o = code_q;
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
// Assertion checker for the SDRAM command monitor, bound to every instance.
// Assumes: synchronous active-low reset; observes ports only.
module sdram_cmd_monitor_chk #(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clr_i,
    input logic                 init_done_i,
    input logic                 cke_i,
    input logic                 cs_n_i,
    input logic                 ras_n_i,
    input logic                 cas_n_i,
    input logic                 we_n_i,
    input logic [BA_W-1:0]      ba_i,
    input logic                 a10_i,
    input logic                 err_pulse_o,
    input logic                 err_sticky_o,
    input logic [3:0]           err_code_o,
    input logic [NUM_BANKS-1:0] bank_open_o
);
    logic armed;
    logic is_cmd, is_rw, is_act, is_pre, is_refmrs;

    // Marks that one clock has passed since reset, so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign is_cmd    = !cs_n_i && !(ras_n_i && cas_n_i && we_n_i);
    assign is_rw     = !cs_n_i && ras_n_i && !cas_n_i;
    assign is_act    = !cs_n_i && !ras_n_i && cas_n_i && we_n_i;
    assign is_pre    = !cs_n_i && !ras_n_i && cas_n_i && !we_n_i;
    assign is_refmrs = !cs_n_i && !ras_n_i && !cas_n_i;

    AST_RW_IDLE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rw && !bank_open_o[ba_i]) |=> err_pulse_o); // R1
    AST_ALLBANK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (is_refmrs && (|bank_open_o)) |=> err_pulse_o); // R2
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |=> bank_open_o[$past(ba_i)]); // R8
    AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && a10_i) |=> (bank_open_o == '0)); // R8
    AST_CKE_LOW_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(cke_i) && is_cmd) |=> err_pulse_o); // R10
    AST_PULSE_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |-> (err_code_o != 4'd0 && err_sticky_o)); // R12
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (err_sticky_o == err_pulse_o)); // R13
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_chk (.*);

// File: tb/tb_sdram_cmd_monitor.sv
`timescale 1ns/1ps
// Bench: table of command vectors with expected pulse/code/bank state,
// then directed tests for reset, clearing and the two long watchdogs.
module tb_sdram_cmd_monitor;
    localparam int RAS_MAX = 10000;
    localparam int REFI    = 1562;
    // Bench command numbers (not the RTL's): 0 nop 1 act 2 rd 3 wr 4 pre 5 ref 6 mrs 7 bst
    localparam int NVEC = 30;
    // {cke, cmd[2:0], ba[1:0], a10, exp_pulse, exp_code[3:0], exp_open[3:0]}
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b1,3'd6,2'd0,1'b0,1'b0,4'd0, 4'b0000},  // 0 mode set
        {1'b1,3'd1,2'd0,1'b0,1'b1,4'd9, 4'b0001},  // 1 R7 act too soon after mode set
        {1'b1,3'd2,2'd0,1'b0,1'b1,4'd3, 4'b0001},  // 2 R3 read 1 clk after act
        {1'b1,3'd2,2'd0,1'b0,1'b0,4'd0, 4'b0001},  // 3 R3 read 2 clks after act ok
        {1'b1,3'd1,2'd1,1'b0,1'b0,4'd0, 4'b0011},  // 4 act b1
        {1'b1,3'd1,2'd2,1'b0,1'b1,4'd8, 4'b0111},  // 5 R6 act-act other bank too close
        {1'b1,3'd4,2'd0,1'b0,1'b0,4'd0, 4'b0110},  // 6 pre b0 at distance 5
        {1'b1,3'd1,2'd0,1'b0,1'b1,4'd4, 4'b0111},  // 7 R4 act 1 clk after pre (also tRC)
        {1'b1,3'd4,2'd1,1'b0,1'b1,4'd5, 4'b0101},  // 8 R5 pre b1 at distance 4
        {1'b1,3'd5,2'd0,1'b0,1'b1,4'd2, 4'b0101},  // 9 R2 refresh with banks open
        {1'b1,3'd2,2'd1,1'b0,1'b1,4'd1, 4'b0101},  // 10 R1 read idle bank
        {1'b1,3'd3,2'd2,1'b1,1'b0,4'd0, 4'b0101},  // 11 R9 write with auto precharge
        {1'b1,3'd2,2'd0,1'b0,1'b1,4'd10,4'b0101},  // 12 R9 read inside burst
        {1'b1,3'd0,2'd0,1'b0,1'b0,4'd0, 4'b0101},  // 13
        {1'b1,3'd0,2'd0,1'b0,1'b0,4'd0, 4'b0101},  // 14
        {1'b1,3'd0,2'd0,1'b0,1'b0,4'd0, 4'b0001},  // 15 R9 bank 2 closes
        {1'b1,3'd1,2'd2,1'b0,1'b1,4'd4, 4'b0101},  // 16 R9 closure starts tRP
        {1'b1,3'd0,2'd0,1'b0,1'b0,4'd0, 4'b0101},  // 17
        {1'b1,3'd1,2'd0,1'b0,1'b1,4'd13,4'b0101},  // 18 R6 act to open bank
        {1'b1,3'd4,2'd3,1'b1,1'b1,4'd5, 4'b0000},  // 19 R8 pre-all ignores ba; R5 on b2
        {1'b1,3'd0,2'd0,1'b0,1'b0,4'd0, 4'b0000},  // 20
        {1'b1,3'd5,2'd0,1'b0,1'b0,4'd0, 4'b0000},  // 21 refresh all idle ok
        {1'b1,3'd0,2'd0,1'b0,1'b0,4'd0, 4'b0000},  // 22
        {1'b1,3'd7,2'd0,1'b0,1'b0,4'd0, 4'b0000},  // 23 burst stop ok
        {1'b1,3'd6,2'd0,1'b0,1'b0,4'd0, 4'b0000},  // 24 mode set
        {1'b0,3'd0,2'd0,1'b0,1'b0,4'd0, 4'b0000},  // 25 clock enable low
        {1'b1,3'd1,2'd3,1'b0,1'b1,4'd11,4'b1000},  // 26 R10 act right after cke low
        {1'b1,3'd0,2'd0,1'b0,1'b0,4'd0, 4'b1000},  // 27
        {1'b1,3'd4,2'd3,1'b0,1'b1,4'd5, 4'b0000},  // 28 R5
        {1'b1,3'd4,2'd3,1'b0,1'b0,4'd0, 4'b0000}   // 29 R8 pre idle bank no effect
    };

    logic       clk = 1'b0, rst_n = 1'b0, clr = 1'b0, init_done = 1'b0, cke = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic       err_pulse, err_sticky;
    logic [3:0] err_code, bank_open;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    sdram_cmd_monitor dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .init_done_i(init_done),
        .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n), .cas_n_i(cas_n),
        .we_n_i(we_n), .ba_i(ba), .a10_i(a10),
        .err_pulse_o(err_pulse), .err_sticky_o(err_sticky),
        .err_code_o(err_code), .bank_open_o(bank_open)
    );

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4, 4'd7: return "R4";  4'd5, 4'd6: return "R5";
            4'd8, 4'd13: return "R6"; 4'd9: return "R7"; 4'd10: return "R9";
            4'd11: return "R10"; 4'd12: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one command at a falling edge and return at the next falling edge.
    task automatic apply(input logic c, input logic [2:0] k, input logic [1:0] b, input logic a);
        cke = c; ba = b; a10 = a; cs_n = (k == 3'd0);
        case (k)
            3'd1: {ras_n, cas_n, we_n} = 3'b011;
            3'd2: {ras_n, cas_n, we_n} = 3'b101;
            3'd3: {ras_n, cas_n, we_n} = 3'b100;
            3'd4: {ras_n, cas_n, we_n} = 3'b010;
            3'd5: {ras_n, cas_n, we_n} = 3'b001;
            3'd6: {ras_n, cas_n, we_n} = 3'b000;
            3'd7: {ras_n, cas_n, we_n} = 3'b110;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
        @(negedge clk);
    endtask

    // Count no-op cycles until the first pulse; returns the count or -1.
    task automatic wait_pulse(input int limit, output int first);
        first = -1;
        for (int k = 1; k <= limit; k++) begin
            apply(1'b1, 3'd0, 2'd0, 1'b0);
            if (err_pulse && first < 0) first = k;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int first;
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13 reset state
        check("R13 reset pulse", err_pulse, 0);
        check("R13 reset sticky", err_sticky, 0);
        check("R13 reset code", err_code, 0);
        check("R8 reset banks", bank_open, 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] v;
            v = VEC[i];
            apply(v[15], v[14:12], v[11:10], v[9]);
            check($sformatf("%s vec %0d pulse", req_of(v[7:4]), i), err_pulse, v[8]);
            if (v[8]) check($sformatf("%s vec %0d code", req_of(v[7:4]), i), err_code, v[7:4]);
            check($sformatf("R8 vec %0d banks", i), bank_open, v[3:0]);
        end

        // R13 sticky held, code held from last error (code 5)
        check("R13 sticky held", err_sticky, 1);
        check("R12 code held", err_code, 5);
        clr = 1'b1; apply(1'b1, 3'd0, 2'd0, 1'b0);
        check("R13 clear sticky", err_sticky, 0);
        check("R13 clear code", err_code, 0);
        apply(1'b1, 3'd2, 2'd1, 1'b0);               // R13 error with clear: error wins
        check("R13 error beats clear sticky", err_sticky, 1);
        check("R13 error beats clear code", err_code, 1);
        apply(1'b1, 3'd0, 2'd0, 1'b0);
        clr = 1'b0;
        check("R13 cleared again", err_sticky, 0);

        // R5 long-open row: pulse exactly RAS_MAX clocks after the activate
        apply(1'b1, 3'd1, 2'd0, 1'b0);
        wait_pulse(RAS_MAX + 5, first);
        check("R5 open-too-long cycle", first, RAS_MAX);
        check("R5 open-too-long code", err_code, 6);
        apply(1'b1, 3'd4, 2'd0, 1'b0);
        check("R8 bank closed after pre", bank_open, 0);

        // R11 refresh watchdog: in-time refreshes stay quiet
        init_done = 1'b1;
        pulses = 0;
        for (int r = 0; r < 3; r++) begin
            apply(1'b1, 3'd5, 2'd0, 1'b0);
            if (err_pulse) pulses++;
            for (int k = 0; k < REFI - 100; k++) begin
                apply(1'b1, 3'd0, 2'd0, 1'b0);
                if (err_pulse) pulses++;
            end
        end
        check("R11 no pulse with timely refresh", pulses, 0);
        apply(1'b1, 3'd5, 2'd0, 1'b0);
        wait_pulse(REFI + 5, first);
        check("R11 late refresh cycle", first, REFI);
        check("R11 late refresh code", err_code, 12);
        init_done = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule